// File: doc/BRIEF.md
# IM-bus Master Serial Controller

This block drives a three-wire IM-bus link as the only master. It produces a shift clock that rests high, an open-drain data line, and an IDENT output that marks each byte as an address (IDENT low) or as data (IDENT high). A host issues one command at a time through a valid/ready handshake: write an address byte, write a data byte, read a data byte, or end the exchange with a stop pulse. A one-cycle done strobe marks the end of every command. A read also returns the captured byte with a one-cycle valid strobe.

Bits travel least-significant first. Outputs change on the falling clock edge, and the slave samples on the rising edge. The data line is never driven high. A 1 releases it so the external pull-up can lift it, and a 0 pulls it low. A read therefore shifts out all ones, which leaves the line free for the slave. The shift-clock half-period comes from a system-clock divider that the host loads with each command. The incoming data line passes through a configurable synchronizer before it is sampled.

Top module: `imbus_master`

## Requirements
- R1: While reset is asserted and right after it is released, `sclk_o`=1, `sda_oe`=0, `ident_o`=1, `cmd_ready`=1, `done`=0 and `rx_valid`=0.
- R2: A write command (`cmd_op`=0 address, 1 data) puts `cmd_byte` on the line least-significant bit first. A slave that samples on each rising `sclk_o` edge collects exactly `cmd_byte`.
- R3: Every byte command gives exactly 8 falling edges on `sclk_o`. Each low phase lasts `half_div`+1 system clocks. `cmd_ready` stays low for 17*(`half_div`+1) cycles: one setup half-period and then 16 clock half-periods.
- R4: For a whole address byte `ident_o` is 0. For a whole data write or read (`cmd_op`=1 or 2) it is 1. It keeps that level after the byte.
- R5: `ident_o` changes only while `sclk_o` is high on both the cycle before and the cycle of the change.
- R6: A read (`cmd_op`=2) never asserts `sda_oe`. The 8 bits sampled at the rising edges, LSB first, appear on `rx_byte` with `rx_valid`=1 in the same cycle as `done`.
- R7: A stop (`cmd_op`=3) drives `ident_o` low for exactly `half_div`+1 cycles and then high. `sclk_o` stays high throughout, and `done` is pulsed in the cycle `ident_o` returns high.
- R8: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the next cycle until `done`. `cmd_valid` while busy has no effect on the transfer in progress.
- R9: Whenever the controller is idle (`cmd_ready`=1), `sclk_o`=1 and `sda_oe`=0.
- R10: `rx_valid` is asserted only on completion of a read. Write and stop commands never assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | Shift-clock half-period minus one, in system clocks; sampled at command acceptance; must be at least SYNC_STAGES |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle and able to accept a command |
| cmd_op | input | 2 | 0 address write, 1 data write, 2 data read, 3 stop |
| cmd_byte | input | 8 | Byte to write (ignored for read and stop) |
| done | output | 1 | One-cycle pulse when a command completes |
| rx_valid | output | 1 | One-cycle pulse with done after a read |
| rx_byte | output | 8 | Byte received by the last read |
| sclk_o | output | 1 | Shift clock, idles high |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |
| sda_i | input | 1 | Level of the data line |
| ident_o | output | 1 | Address (0) / data (1) marker and stop pulse |

## Verification
Writes use bytes with a single set bit at either end, such as 0x01 and 0x80. These reveal a reversed bit order that a symmetric byte would hide. Reads of 0x00, 0xFF and 0xA5 show whether the master ever drives the line and whether the captured bits are reordered. A stop issued right after an address byte, while IDENT is already low, separates a real timed low phase from an edge-triggered pulse. Random command streams with divider values from 2 to 5 exercise the phase lengths, IDENT transitions between byte kinds, and junk commands presented while the controller is busy.

// File: rtl/imbus_pkg.sv
package imbus_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = $clog2(BYTE_W);

   typedef enum logic [1:0] {
      OP_ADDR = 2'd0,
      OP_DATA = 2'd1,
      OP_READ = 2'd2,
      OP_STOP = 2'd3
   } imb_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_STOP
   } imb_state_e;

endpackage

// File: rtl/imbus_phase_timer.sv
module imbus_phase_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);
   logic [DIV_W-1:0] limit_q;
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= '0;
         cnt_q   <= '0;
      end else begin
         if (load) begin
            limit_q <= div_in;
         end
         if (!run || tick) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/imbus_in_sync.sv
module imbus_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '1;
            end else if (STAGES == 1) begin
               pipe_q[0] <= din;
            end else begin
               pipe_q <= {pipe_q[STAGES-2:0], din};
            end
         end
         assign dout = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/imbus_shifter.sv
module imbus_shifter
   import imbus_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] tx_in,
   input  logic              advance,
   input  logic              capture,
   input  logic              din,
   output logic              tx_bit,
   output logic [BYTE_W-1:0] rx_q
);
   logic [BYTE_W-1:0] tx_q;

   assign tx_bit = tx_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '1;
         rx_q <= '0;
      end else begin
         if (load) begin
            tx_q <= tx_in;
         end else if (advance) begin
            tx_q <= {1'b1, tx_q[BYTE_W-1:1]};
         end
         if (capture) begin
            rx_q <= {din, rx_q[BYTE_W-1:1]};
         end
      end
   end
endmodule

// File: rtl/imbus_seq.sv
module imbus_seq
   import imbus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       tick,
   output logic       cmd_ready,
   output logic       run,
   output logic       load_div,
   output logic       load_tx,
   output logic       rd_now,
   output logic       advance,
   output logic       capture,
   output logic       drive_en,
   output logic       sclk_o,
   output logic       ident_o,
   output logic       done,
   output logic       rx_valid
);
   imb_state_e           state_q;
   logic [BIT_CNT_W-1:0] bit_q;
   logic                 rd_q;
   imb_op_e              op;
   logic                 accept;
   logic                 last_bit;

   assign op        = imb_op_e'(cmd_op);
   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_ready && cmd_valid;
   assign run       = !cmd_ready;
   assign load_div  = accept;
   assign load_tx   = accept && (op != OP_STOP);
   assign rd_now    = (op == OP_READ);
   assign last_bit  = (bit_q == BIT_CNT_W'(BYTE_W - 1));
   assign advance   = tick && (state_q == ST_HIGH) && !last_bit;
   assign capture   = tick && (state_q == ST_LOW) && rd_q;
   assign drive_en  = (state_q == ST_LOW) || (state_q == ST_HIGH);
   assign sclk_o    = (state_q != ST_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bit_q    <= '0;
         rd_q     <= 1'b0;
         ident_o  <= 1'b1;
         done     <= 1'b0;
         rx_valid <= 1'b0;
      end else begin
         done     <= 1'b0;
         rx_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  bit_q <= '0;
                  rd_q  <= (op == OP_READ);
                  if (op == OP_STOP) begin
                     ident_o <= 1'b0;
                     state_q <= ST_STOP;
                  end else begin
                     ident_o <= (op != OP_ADDR);
                     state_q <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: begin
               if (tick) state_q <= ST_LOW;
            end
            ST_LOW: begin
               if (tick) state_q <= ST_HIGH;
            end
            ST_HIGH: begin
               if (tick) begin
                  if (last_bit) begin
                     state_q  <= ST_IDLE;
                     done     <= 1'b1;
                     rx_valid <= rd_q;
                  end else begin
                     bit_q   <= bit_q + 1'b1;
                     state_q <= ST_LOW;
                  end
               end
            end
            ST_STOP: begin
               if (tick) begin
                  ident_o <= 1'b1;
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/imbus_master.sv
module imbus_master
   import imbus_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_div,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [1:0]       cmd_op,
   input  logic [7:0]       cmd_byte,
   output logic             done,
   output logic             rx_valid,
   output logic [7:0]       rx_byte,
   output logic             sclk_o,
   output logic             sda_oe,
   input  logic             sda_i,
   output logic             ident_o
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("imbus_master: DIV_W must be 1..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("imbus_master: SYNC_STAGES must be 0..3");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("imbus_master: byte width must be 8");
      end
   endgenerate

   logic       tick;
   logic       run;
   logic       load_div;
   logic       load_tx;
   logic       rd_now;
   logic       advance;
   logic       capture;
   logic       drive_en;
   logic       tx_bit;
   logic       sda_sync;
   logic [7:0] tx_in;

   assign tx_in  = rd_now ? 8'hFF : cmd_byte;
   assign sda_oe = drive_en && !tx_bit;

   imbus_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .tick      (tick),
      .cmd_ready (cmd_ready),
      .run       (run),
      .load_div  (load_div),
      .load_tx   (load_tx),
      .rd_now    (rd_now),
      .advance   (advance),
      .capture   (capture),
      .drive_en  (drive_en),
      .sclk_o    (sclk_o),
      .ident_o   (ident_o),
      .done      (done),
      .rx_valid  (rx_valid)
   );

   imbus_phase_timer #(.DIV_W(DIV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .load   (load_div),
      .div_in (half_div),
      .tick   (tick)
   );

   imbus_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sda_i),
      .dout  (sda_sync)
   );

   imbus_shifter u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_tx),
      .tx_in   (tx_in),
      .advance (advance),
      .capture (capture),
      .din     (sda_sync),
      .tx_bit  (tx_bit),
      .rx_q    (rx_byte)
   );
endmodule

// File: rtl/imbus_master_chk.sv
module imbus_master_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] half_div,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [1:0]       cmd_op,
   input logic             done,
   input logic             rx_valid,
   input logic             sclk_o,
   input logic             sda_oe,
   input logic             ident_o
);
   logic [DIV_W:0]  hd_q;
   logic [DIV_W:0]  low_cnt;
   logic            rd_q;
   logic            stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hd_q    <= '0;
         low_cnt <= '0;
         rd_q    <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         if (cmd_valid && cmd_ready) begin
            hd_q   <= {1'b0, half_div} + 1'b1;
            rd_q   <= (cmd_op == 2'd2);
            stop_q <= (cmd_op == 2'd3);
         end
         if (!sclk_o) low_cnt <= low_cnt + 1'b1;
         else         low_cnt <= '0;
      end
   end

   assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (sclk_o && !sda_oe));

   assert_ident_clock_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ident_o != $past(ident_o)) |-> (sclk_o && $past(sclk_o)));

   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   assert_rx_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> done);

   assert_read_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && rd_q) |-> !sda_oe);

   assert_low_phase_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> (low_cnt == hd_q));

   assert_stop_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && stop_q) |-> sclk_o);
endmodule

bind imbus_master imbus_master_chk #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .half_div  (half_div),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .done      (done),
   .rx_valid  (rx_valid),
   .sclk_o    (sclk_o),
   .sda_oe    (sda_oe),
   .ident_o   (ident_o)
);

// File: tb/sim_imbus_master.sv
`timescale 1ns/1ps
module sim_imbus_master;
   localparam int DIV_W = 8;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic             cmd_valid = 1'b0;
   logic [1:0]       cmd_op = 2'd0;
   logic [7:0]       cmd_byte = 8'd0;
   logic [DIV_W-1:0] half_div = 8'd2;
   logic             cmd_ready, done, rx_valid, sclk_o, sda_oe, ident_o;
   logic [7:0]       rx_byte;
   logic             s_oe;
   wire              sda_line = !(sda_oe || s_oe);

   imbus_master #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .half_div(half_div),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_byte(cmd_byte), .done(done), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .sclk_o(sclk_o), .sda_oe(sda_oe),
      .sda_i(sda_line), .ident_o(ident_o)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic exp_ident(input logic [1:0] op);
      return (op != 2'd0);
   endfunction

   function automatic int exp_busy(input int hd, input logic [1:0] op);
      return (op == 2'd3) ? (hd + 1) : 17 * (hd + 1);
   endfunction

   // slave model: samples on rising sclk, drives on falling sclk
   logic       slave_en = 1'b0;
   logic [7:0] slave_tx = 8'd0;
   logic [7:0] s_shift;
   logic [7:0] s_byte;
   logic       s_ident, s_ident_bad, prev_sclk;
   int         s_bits, s_count;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_sclk   <= 1'b1;
         s_oe        <= 1'b0;
         s_bits      <= 0;
         s_count     <= 0;
         s_shift     <= 8'd0;
         s_byte      <= 8'd0;
         s_ident     <= 1'b1;
         s_ident_bad <= 1'b0;
      end else begin
         logic [7:0] nx;
         prev_sclk <= sclk_o;
         if (prev_sclk && !sclk_o) begin
            if (slave_en) s_oe <= ~slave_tx[s_bits[2:0]];
         end else if (!prev_sclk && sclk_o) begin
            nx = {sda_line, s_shift[7:1]};
            s_shift <= nx;
            if (s_bits == 0) begin
               s_ident     <= ident_o;
               s_ident_bad <= 1'b0;
            end else if (ident_o != s_ident) begin
               s_ident_bad <= 1'b1;
            end
            if (s_bits == 7) begin
               s_byte  <= nx;
               s_count <= s_count + 1;
               s_bits  <= 0;
               s_oe    <= 1'b0;
            end else begin
               s_bits <= s_bits + 1;
            end
         end
      end
   end

   task automatic do_cmd(input logic [1:0] op, input logic [7:0] b,
                         input logic [7:0] stx, input int hd, input bit junk);
      int busy, lows, falls, identlow, start;
      bit oe_seen, rxv_early, prev;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      half_div = DIV_W'(hd);
      slave_en = (op == 2'd2);
      slave_tx = stx;
      start    = s_count;
      cmd_op   = op;
      cmd_byte = b;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = junk;
      if (junk) begin
         cmd_op   = op ^ 2'd1;
         cmd_byte = ~b;
         half_div = DIV_W'(hd + 3);
      end
      check(cmd_ready == 1'b0, "R8 ready low after accept", int'(cmd_ready), 0);
      busy = 0; lows = 0; falls = 0; identlow = 0; oe_seen = 0; rxv_early = 0;
      prev = 1'b1;
      while (!done && busy < 5000) begin
         busy++;
         if (busy == 3) cmd_valid = 1'b0;
         if (!sclk_o) lows++;
         if (prev && !sclk_o) falls++;
         prev = sclk_o;
         if (sda_oe) oe_seen = 1;
         if (!ident_o) identlow++;
         if (rx_valid) rxv_early = 1;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      check(cmd_ready == 1'b1, "R8 ready with done", int'(cmd_ready), 1);
      check(busy == exp_busy(hd, op), (op == 2'd3) ? "R7 stop length" : "R3 byte length",
            busy, exp_busy(hd, op));
      check(rxv_early == 0, "R10 no early rx_valid", int'(rxv_early), 0);
      if (op == 2'd3) begin
         check(identlow == hd + 1, "R7 ident low time", identlow, hd + 1);
         check(falls == 0, "R7 clock high in stop", falls, 0);
         check(ident_o == 1'b1, "R7 ident high after stop", int'(ident_o), 1);
         check(rx_valid == 1'b0, "R10 no rx_valid on stop", int'(rx_valid), 0);
      end else begin
         check(falls == 8, "R3 falling edges", falls, 8);
         check(lows == 8 * (hd + 1), "R3 low phase total", lows, 8 * (hd + 1));
         check(s_count == start + 1, "R3 slave byte count", s_count - start, 1);
         check(s_ident == exp_ident(op) && !s_ident_bad, "R4 ident during byte",
               int'(s_ident), int'(exp_ident(op)));
         check(identlow == (exp_ident(op) ? 0 : busy), "R4 ident level whole byte",
               identlow, exp_ident(op) ? 0 : busy);
         check(ident_o == exp_ident(op), "R4 ident held after byte",
               int'(ident_o), int'(exp_ident(op)));
         if (op == 2'd2) begin
            check(oe_seen == 0, "R6 line released in read", int'(oe_seen), 0);
            check(rx_valid == 1'b1, "R6 rx_valid with done", int'(rx_valid), 1);
            check(rx_byte == stx, "R6 received byte", int'(rx_byte), int'(stx));
            check(s_byte == stx, "R6 line carried slave byte", int'(s_byte), int'(stx));
         end else begin
            check(s_byte == b, "R2 LSB-first byte at slave", int'(s_byte), int'(b));
            check(rx_valid == 1'b0, "R10 no rx_valid on write", int'(rx_valid), 0);
         end
      end
      slave_en = 1'b0;
   endtask

   initial begin
      #(8.0 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(sclk_o && !sda_oe && ident_o && cmd_ready && !done && !rx_valid,
            "R1 lines during reset", int'({sclk_o, sda_oe, ident_o, cmd_ready}), 4'b1011);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sclk_o && !sda_oe && ident_o && cmd_ready && !done && !rx_valid,
            "R1 lines after reset", int'({sclk_o, sda_oe, ident_o, cmd_ready}), 4'b1011);

      do_cmd(2'd0, 8'h01, 8'h00, 2, 0);
      do_cmd(2'd1, 8'h80, 8'h00, 2, 0);
      do_cmd(2'd2, 8'h00, 8'hA5, 3, 0);
      do_cmd(2'd2, 8'h00, 8'h00, 2, 0);
      do_cmd(2'd2, 8'h00, 8'hFF, 2, 0);
      do_cmd(2'd3, 8'h00, 8'h00, 2, 0);
      do_cmd(2'd0, 8'h3C, 8'h00, 4, 0);
      do_cmd(2'd3, 8'h00, 8'h00, 4, 0);
      do_cmd(2'd1, 8'h5A, 8'h00, 3, 1);
      do_cmd(2'd2, 8'h00, 8'h6E, 5, 1);

      for (int i = 0; i < 40; i++) begin
         logic [1:0] op;
         op = 2'($urandom_range(0, 3));
         do_cmd(op, 8'($urandom), 8'($urandom), int'($urandom_range(2, 5)),
                bit'($urandom_range(0, 1)));
      end

      repeat (4) @(negedge clk);
      check(sclk_o && !sda_oe && cmd_ready, "R9 idle lines at end",
            int'({sclk_o, sda_oe, cmd_ready}), 3'b101);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule